// File: doc/BRIEF.md
# I2C Register Target with 16-bit Pointer

This block is an I2C target. It lets a host reach an on-chip register file through a 16-bit register pointer. The SCL and SDA pad inputs are first brought into the system clock domain. The block then finds START and STOP conditions, compares the first byte of each transfer with a fixed 7-bit device address, and pulls SDA low through an open-drain enable when it must drive a zero. The system clock must run at least eight times faster than SCL.

A write transfer has this shape: device address with R/W = 0, pointer high byte, pointer low byte, then the register value. The value has 1, 2 or 4 bytes, sent most significant byte first. A read takes two steps. First a write-direction transfer loads only the pointer. Then a read-direction transfer, started after a STOP or a repeated START, returns the register value most significant byte first.

Register width comes from an external lookup, which answers a 2-bit code for the current pointer. The register port is plain: a pointer, write data, a one-cycle write strobe and read data. It has no back-pressure. The register file must accept a strobe in any cycle and must present read data combinationally for the pointer shown. A stream handshake would add nothing here, because the I2C bit rate is far below the system clock.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), `reg_we` is low and `reg_addr` is 0.
- R2: The target acknowledges an address byte whose upper 7 bits equal DEV_ADDR (default 7'b0111000, so 0x70 writes and 0x71 reads). For any other address byte it never drives SDA and never strobes a write until the next START.
- R3: The target acknowledges each byte it receives: the address byte, both pointer bytes, and each data byte up to the register width. The ACK is driven low during the ninth SCL pulse. SDA drive changes only while SCL is low.
- R4: The two pointer bytes arrive high byte first, MSB first within each byte. They appear on `reg_addr` and stay there until new pointer bytes are received.
- R5: Width code on `reg_width`: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes, and 2'b11 is treated as 1 byte. After the last data byte of that width has been acknowledged, `reg_we` pulses for exactly one cycle. At that moment `reg_wdata` holds the received bytes, right-aligned, with the first byte as the most significant.
- R6: A data byte beyond the register width is not acknowledged and causes no further strobe.
- R7: A read-direction transfer returns the width's number of bytes from `reg_rdata`, most significant byte first, MSB first within each byte. It uses the pointer last loaded, which is kept across transfers.
- R8: A host NACK after any byte of a read ends the read. SDA stays released for all later SCL pulses until the next START.
- R9: A repeated START restarts address matching from any state. A write cut short by a START or a STOP before its final byte produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| reg_addr | output | 16 | Register pointer |
| reg_width | input | 2 | Width code for `reg_addr`, supplied by the lookup |
| reg_rdata | input | 32 | Read data for `reg_addr`, right-aligned |
| reg_wdata | output | 32 | Write data, right-aligned |
| reg_we | output | 1 | One-cycle write strobe |

## Verification
The bench builds the target with its default device address of 0x38 and two synchroniser stages. This lets both 0x70/0x71 and neighbouring addresses such as 0x72/0x73 be sent, so a match and a miss can be compared directly. The bench's width lookup takes the width code from the two low pointer bits. Every width code, including the reserved one, is therefore reached just by choosing the pointer. SCL runs at forty system clocks per bit, well above the minimum ratio, so every ACK and data edge settles well inside the SCL low phase.

// File: rtl/i2c_reg_target_pkg.sv
package i2c_reg_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RX,     // shifting in a byte
    ST_ACK,    // driving ACK for a received byte
    ST_TX,     // shifting out a read byte
    ST_HACK    // listening to the host ACK/NACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_DEV,    // device address byte
    PH_PHI,    // pointer high byte
    PH_PLO,    // pointer low byte
    PH_DAT     // register data bytes
  } tgt_phase_e;

  // width code -> number of data bytes (code 3 is reserved and treated as 1)
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic dprev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dprev <= 1'b1;
    else        dprev <= dout;
endmodule

// File: rtl/i2c_rt_cond.sv
module i2c_rt_cond (
  input  logic scl_now,
  input  logic scl_prev,
  input  logic sda_now,
  input  logic sda_prev,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  // SDA moving while SCL stays high marks a bus condition
  assign start_o = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign rise_o  = scl_now & ~scl_prev;
  assign fall_o  = ~scl_now & scl_prev;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b0111000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [15:0] reg_addr,
  input  logic [1:0]  reg_width,
  input  logic [31:0] reg_rdata,
  output logic [31:0] reg_wdata,
  output logic        reg_we
);
  import i2c_reg_target_pkg::*;

  localparam int LINES = 2;   // index 1 = SCL, index 0 = SDA

  logic [LINES-1:0] pad_raw, pad_now, pad_prev;
  logic start, stop, scl_rise, scl_fall;

  assign pad_raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_sync
      i2c_rt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_raw[g]),
        .dout  (pad_now[g]),
        .dprev (pad_prev[g])
      );
    end
  endgenerate

  i2c_rt_cond u_cond (
    .scl_now  (pad_now[1]),
    .scl_prev (pad_prev[1]),
    .sda_now  (pad_now[0]),
    .sda_prev (pad_prev[0]),
    .start_o  (start),
    .stop_o   (stop),
    .rise_o   (scl_rise),
    .fall_o   (scl_fall)
  );

  tgt_state_e st;
  tgt_phase_e ph;
  logic        rd_dir;
  logic [7:0]  rx_sh, tx_sh;
  logic [3:0]  bcnt;
  logic [2:0]  didx;
  logic        host_ack;
  logic [15:0] ptr;
  logic [31:0] wacc;
  logic        we_q;

  logic [2:0] nbytes;
  logic [2:0] sel_idx;
  logic [1:0] lane;
  logic [7:0] rd_byte;

  assign nbytes  = width_bytes(reg_width);
  // the first byte loads from ACK, later ones from HACK (didx already advanced)
  assign sel_idx = (st == ST_HACK) ? didx : 3'd0;
  assign lane    = 2'(nbytes - 3'd1 - sel_idx);

  always_comb begin
    case (lane)
      2'd0:    rd_byte = reg_rdata[7:0];
      2'd1:    rd_byte = reg_rdata[15:8];
      2'd2:    rd_byte = reg_rdata[23:16];
      default: rd_byte = reg_rdata[31:24];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_DEV;
      rd_dir   <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      bcnt     <= '0;
      didx     <= '0;
      host_ack <= 1'b0;
      ptr      <= '0;
      wacc     <= '0;
      we_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start) begin
        st   <= ST_RX;
        ph   <= PH_DEV;
        bcnt <= '0;
      end else if (stop) begin
        st <= ST_IDLE;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && bcnt < 4'd8) begin
              rx_sh <= {rx_sh[6:0], pad_now[0]};
              bcnt  <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8) begin
              bcnt <= '0;
              case (ph)
                PH_DEV: begin
                  if (rx_sh[7:1] == DEV_ADDR) begin
                    rd_dir <= rx_sh[0];
                    st     <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_PHI: begin
                  ptr[15:8] <= rx_sh;
                  st        <= ST_ACK;
                end
                PH_PLO: begin
                  ptr[7:0] <= rx_sh;
                  st       <= ST_ACK;
                end
                default: begin
                  if (didx < nbytes) begin
                    wacc <= {wacc[23:0], rx_sh};
                    didx <= didx + 3'd1;
                    st   <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              case (ph)
                PH_DEV: begin
                  if (rd_dir) begin
                    didx  <= '0;
                    tx_sh <= rd_byte;
                    bcnt  <= '0;
                    st    <= ST_TX;
                  end else begin
                    ph <= PH_PHI;
                    st <= ST_RX;
                  end
                end
                PH_PHI: begin
                  ph <= PH_PLO;
                  st <= ST_RX;
                end
                PH_PLO: begin
                  ph   <= PH_DAT;
                  didx <= '0;
                  wacc <= '0;
                  st   <= ST_RX;
                end
                default: begin
                  st <= ST_RX;
                  if (didx == nbytes) we_q <= 1'b1;
                end
              endcase
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == 4'd7) begin
                bcnt <= '0;
                didx <= didx + 3'd1;
                st   <= ST_HACK;
              end else begin
                tx_sh <= {tx_sh[6:0], 1'b0};
                bcnt  <= bcnt + 4'd1;
              end
            end
          end
          ST_HACK: begin
            if (scl_rise) begin
              host_ack <= ~pad_now[0];
            end else if (scl_fall) begin
              if (host_ack && didx < nbytes) begin
                tx_sh <= rd_byte;
                st    <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = (st == ST_ACK) | ((st == ST_TX) & ~tx_sh[7]);
  assign reg_addr  = ptr;
  assign reg_wdata = wacc;
  assign reg_we    = we_q;
endmodule

// File: rtl/i2c_rt_chk.sv
module i2c_rt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic        reg_we,
  input logic [15:0] reg_addr
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (!sda_oe && !reg_we));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R4
  pointer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));

  // R3
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R8
  release_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);
endmodule

bind i2c_reg_target i2c_rt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .reg_we   (reg_we),
  .reg_addr (reg_addr)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int Q = 10;   // quarter SCL bit in system clocks

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl, host_sda, sda, sda_oe;
  logic [15:0] reg_addr;
  logic [1:0]  reg_width;
  logic [31:0] reg_rdata, reg_wdata;
  logic        reg_we;
  logic [31:0] mem [16];
  int we_cnt;
  logic [15:0] we_addr;
  logic [31:0] we_data;
  int drive_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;

  assign sda       = host_sda & ~sda_oe;   // wired-AND line
  assign reg_width = reg_addr[1:0];
  assign reg_rdata = mem[reg_addr[3:0]];

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_width(reg_width), .reg_rdata(reg_rdata),
    .reg_wdata(reg_wdata), .reg_we(reg_we)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= {8{i[3:0]}};
      we_cnt <= 0;
    end else if (reg_we) begin
      mem[reg_addr[3:0]] <= reg_wdata;
      we_cnt  <= we_cnt + 1;
      we_addr <= reg_addr;
      we_data <= reg_wdata;
    end
  end

  always @(negedge clk) if (sda_oe) drive_cnt <= drive_cnt + 1;

  localparam logic [47:0] VEC [6] = '{
    48'h0000_000000A5, 48'h0001_0000BEEF, 48'h0002_12345678,
    48'h0003_0000003C, 48'h0105_00008001, 48'h00FE_CAFE0001
  };

  function automatic int nb(input logic [1:0] code);
    return (code == 2'b01) ? 2 : (code == 2'b10) ? 4 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bitx(input logic b, output logic s);
    host_sda = b; wq(Q); scl = 1'b1; wq(Q); s = sda; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic start_c;
    host_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); host_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic stop_c;
    host_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); host_sda = 1'b1; wq(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitx(b[i], s);
    bitx(1'b1, s);
    acked = (s == 1'b0);
  endtask

  task automatic rx_byte(input logic ack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin bitx(1'b1, s); b = {b[6:0], s}; end
    bitx(~ack, s);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] b;
    logic [31:0] r;
    int c0, dc;
    rst_n = 1'b0; scl = 1'b1; host_sda = 1'b1;
    wq(5); rst_n = 1'b1; wq(3);
    chk(!sda_oe, "R1 sda released", 32'(sda_oe), 0);
    chk(!reg_we, "R1 no strobe", 32'(reg_we), 0);
    chk(reg_addr == 16'h0, "R1 pointer zero", 32'(reg_addr), 0);

    for (int v = 0; v < 6; v++) begin
      logic [15:0] a;
      logic [31:0] d;
      int n;
      a = VEC[v][47:32]; d = VEC[v][31:0]; n = nb(a[1:0]); c0 = we_cnt;
      start_c();
      tx_byte(8'h70, ak); chk(ak, "R2 write address ack", 32'(ak), 1);
      tx_byte(a[15:8], ak); chk(ak, "R3 pointer hi ack", 32'(ak), 1);
      tx_byte(a[7:0], ak);  chk(ak, "R3 pointer lo ack", 32'(ak), 1);
      chk(reg_addr == a, "R4 pointer", 32'(reg_addr), 32'(a));
      for (int k = n - 1; k >= 0; k--) begin
        tx_byte(d[8*k +: 8], ak); chk(ak, "R3 data ack", 32'(ak), 1);
      end
      stop_c();
      chk(we_cnt == c0 + 1, "R5 strobe count", 32'(we_cnt), 32'(c0 + 1));
      chk(we_data == d, "R5 write data", we_data, d);
      chk(we_addr == a, "R5 write address", 32'(we_addr), 32'(a));
      start_c();
      tx_byte(8'h70, ak); tx_byte(a[15:8], ak); tx_byte(a[7:0], ak);
      start_c();
      tx_byte(8'h71, ak); chk(ak, "R9 repeated start read ack", 32'(ak), 1);
      r = '0;
      for (int k = 0; k < n; k++) begin rx_byte(k != n - 1, b); r = {r[23:0], b}; end
      stop_c();
      chk(r == d, "R7 read back", r, d);
      chk(!sda_oe, "R8 released after read", 32'(sda_oe), 0);
    end

    // R2: non-matching addresses
    c0 = we_cnt; dc = drive_cnt;
    start_c();
    tx_byte(8'h72, ak); chk(!ak, "R2 wrong address nack", 32'(ak), 0);
    tx_byte(8'h00, ak); tx_byte(8'h00, ak); tx_byte(8'h55, ak);
    stop_c();
    start_c();
    tx_byte(8'h73, ak); chk(!ak, "R2 wrong read address nack", 32'(ak), 0);
    rx_byte(1'b1, b);
    stop_c();
    chk(drive_cnt == dc, "R2 never drives", 32'(drive_cnt), 32'(dc));
    chk(we_cnt == c0, "R2 no strobe", 32'(we_cnt), 32'(c0));

    // R6: byte beyond width
    c0 = we_cnt;
    start_c();
    tx_byte(8'h70, ak); tx_byte(8'h00, ak); tx_byte(8'h00, ak);
    tx_byte(8'h5A, ak); chk(ak, "R6 first byte ack", 32'(ak), 1);
    tx_byte(8'h77, ak); chk(!ak, "R6 extra byte nack", 32'(ak), 0);
    stop_c();
    chk(we_cnt == c0 + 1, "R6 single strobe", 32'(we_cnt), 32'(c0 + 1));
    chk(we_data == 32'h5A, "R6 data kept", we_data, 32'h5A);

    // R9: interrupted writes
    c0 = we_cnt;
    start_c();
    tx_byte(8'h70, ak); tx_byte(8'h00, ak); tx_byte(8'h02, ak);
    tx_byte(8'h99, ak); tx_byte(8'h88, ak);
    stop_c();
    chk(we_cnt == c0, "R9 stop before final byte", 32'(we_cnt), 32'(c0));
    start_c();
    tx_byte(8'h70, ak); tx_byte(8'h00, ak); tx_byte(8'h02, ak); tx_byte(8'h11, ak);
    start_c();
    tx_byte(8'h71, ak); chk(ak, "R9 restart matches", 32'(ak), 1);
    r = '0;
    for (int k = 0; k < 4; k++) begin rx_byte(k != 3, b); r = {r[23:0], b}; end
    stop_c();
    chk(r == 32'h12345678, "R9 register untouched", r, 32'h12345678);
    chk(we_cnt == c0, "R9 restart before final byte", 32'(we_cnt), 32'(c0));

    // R7: pointer kept across transfers
    start_c();
    tx_byte(8'h71, ak);
    r = '0;
    for (int k = 0; k < 4; k++) begin rx_byte(k != 3, b); r = {r[23:0], b}; end
    stop_c();
    chk(r == 32'h12345678, "R7 pointer retained", r, 32'h12345678);

    // R8: early host NACK
    start_c();
    tx_byte(8'h71, ak);
    rx_byte(1'b0, b);
    chk(b == 8'h12, "R8 first byte", 32'(b), 32'h12);
    dc = drive_cnt;
    for (int k = 0; k < 9; k++) bitx(1'b1, ak);
    chk(drive_cnt == dc, "R8 no drive after nack", 32'(drive_cnt), 32'(dc));
    stop_c();
    start_c();
    tx_byte(8'h71, ak); chk(ak, "R8 next transfer ack", 32'(ak), 1);
    r = '0;
    for (int k = 0; k < 4; k++) begin rx_byte(k != 3, b); r = {r[23:0], b}; end
    stop_c();
    chk(r == 32'h12345678, "R8 read after nack", r, 32'h12345678);

    report();
    $finish;
  end
endmodule